// File: doc/BRIEF.md
# Predicated Immediate ALU Executor

This block executes one 32-bit arithmetic or logic instruction per cycle. The second operand of the instruction is an immediate value. The block owns a sixteen-entry file of 32-bit registers and a single zero flag. When `instr_valid` is high, the block decodes `instr_word`. It then tests the instruction's 4-bit condition code against the zero flag. If the test passes, it combines the source register with the 12-bit immediate, zero-extended to 32 bits, and writes the result to the destination register.

The outcome of each instruction appears one cycle later as a single-cycle pulse on exactly one of three outputs:

- `retire`: the instruction executed.
- `skipped`: the condition was false.
- `illegal`: the condition passed but the opcode is unknown.

A combinational read port and the `z_flag` output expose the architectural state to the surrounding logic. Memory access, branches and other instruction formats are not handled here.

Top module: `ialu_exec`

## Requirements
- R1: Field layout of `instr_word`:

  | Bits | Field |
  |---|---|
  | [31:28] | condition |
  | [27:21] | opcode |
  | [20] | status-update bit |
  | [19:16] | source register |
  | [15:12] | destination register |
  | [11:0] | immediate |

- R2: Condition 4'b0000 passes only when Z is 1. Condition 4'b0001 passes only when Z is 0. Condition 4'b1110 always passes. Every other condition code never passes.
- R3: For a passing instruction, the destination register receives the source register combined with the zero-extended immediate, with 32-bit wrap-around arithmetic. The opcodes are:

  | Opcode | Operation |
  |---|---|
  | 7'h04 | add |
  | 7'h02 | subtract (source minus immediate) |
  | 7'h00 | bitwise AND |
  | 7'h0C | bitwise OR |
  | 7'h01 | bitwise XOR |

- R4: The register write takes effect on the clock edge that samples `instr_valid`. `retire` is high for exactly the one following cycle. The new value is visible on `rd_data` in that same cycle.
- R5: An instruction whose condition fails writes no register and leaves Z unchanged. It raises `skipped` for one cycle. This holds whatever its opcode is.
- R6: A passing instruction with any opcode not listed in R3 writes no register and leaves Z unchanged. It raises `illegal` for one cycle.
- R7: With the status-update bit at 0, Z is left unchanged. With it at 1, a retired instruction sets Z to 1 exactly when its 32-bit result is zero, and to 0 otherwise.
- R8: A synchronous active-high `rst` clears all registers, Z and the three pulse outputs.
- R9: When the source and destination are the same register, the source operand is that register's value before the write.
- R10: In a cycle following one without `instr_valid`, none of `retire`, `skipped` or `illegal` is high, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction to execute |
| rd_sel | input | 4 | Register index for the read port |
| rd_data | output | 32 | Contents of register `rd_sel` |
| z_flag | output | 1 | Current zero flag |
| retire | output | 1 | Previous instruction executed |
| skipped | output | 1 | Previous instruction's condition failed |
| illegal | output | 1 | Previous instruction had an unknown opcode |

## Verification
The bench drives the zero flag through both values so that the equal and not-equal conditions are each seen passing and failing. A predicate inverted or tied off would write registers that should stay untouched. The bench covers the following cases:

- Reserved condition codes combined with an unknown opcode. These separate a design that checks the opcode first, which would pulse `illegal` instead of `skipped`.
- An instruction whose source and destination are the same register. This catches forwarding of the new value.
- A subtraction that wraps from zero to all ones, followed by an addition that wraps back to zero with the status-update bit set. This exposes a missing zero-extension or a wrong Z update.
- Status-update-clear instructions that produce zero. A design that updates Z regardless of the bit would flip the condition tests that follow.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 16;
    localparam int RA_W    = $clog2(REG_CNT);
    localparam int IMM_W   = 12;
    localparam int OPC_W   = 7;
    localparam int CC_W    = 4;

    // condition encodings
    localparam logic [CC_W-1:0] CC_ZSET   = 4'b0000;
    localparam logic [CC_W-1:0] CC_ZCLR   = 4'b0001;
    localparam logic [CC_W-1:0] CC_ALWAYS = 4'b1110;

    // opcode encodings
    localparam logic [OPC_W-1:0] OPC_ADD = 7'h04;
    localparam logic [OPC_W-1:0] OPC_SUB = 7'h02;
    localparam logic [OPC_W-1:0] OPC_AND = 7'h00;
    localparam logic [OPC_W-1:0] OPC_ORR = 7'h0C;
    localparam logic [OPC_W-1:0] OPC_EOR = 7'h01;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_ORR,
        ALU_EOR,
        ALU_NONE
    } alu_sel_e;

    typedef struct packed {
        logic [CC_W-1:0]  cond;
        logic [OPC_W-1:0] opc;
        logic             upd_z;
        logic [RA_W-1:0]  src;
        logic [RA_W-1:0]  dst;
        logic [IMM_W-1:0] imm;
    } instr_t;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
    import ialu_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output instr_t          fields,
    output alu_sel_e        sel,
    output logic            legal
);
    always_comb begin
        fields = instr_t'(word);
        legal  = 1'b1;
        unique case (fields.opc)
            OPC_ADD: sel = ALU_ADD;
            OPC_SUB: sel = ALU_SUB;
            OPC_AND: sel = ALU_AND;
            OPC_ORR: sel = ALU_ORR;
            OPC_EOR: sel = ALU_EOR;
            default: begin
                sel   = ALU_NONE;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ialu_cond.sv
module ialu_cond
    import ialu_pkg::*;
(
    input  logic [CC_W-1:0] cond,
    input  logic            z,
    output logic            pass
);
    always_comb begin
        unique case (cond)
            CC_ZSET:   pass = z;
            CC_ZCLR:   pass = ~z;
            CC_ALWAYS: pass = 1'b1;
            default:   pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/ialu_alu.sv
module ialu_alu
    import ialu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  alu_sel_e      sel,
    input  logic [W-1:0]  a,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  y,
    output logic          zero
);
    localparam int PAD = W - IW;

    logic [W-1:0] b;

    always_comb begin
        b = {{PAD{1'b0}}, imm};
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_ORR: y = a | b;
            ALU_EOR: y = a ^ b;
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
    import ialu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_word,
    input  logic [RA_W-1:0] rd_sel,
    output logic [XLEN-1:0] rd_data,
    output logic            z_flag,
    output logic            retire,
    output logic            skipped,
    output logic            illegal
);
    typedef struct packed {
        logic [REG_CNT-1:0][XLEN-1:0] rf;
        logic                         z;
        logic                         retire;
        logic                         skipped;
        logic                         illegal;
    } state_t;

    state_t   st_d, st_q;
    instr_t   fld;
    alu_sel_e sel;
    logic     legal;
    logic     pass;
    logic [XLEN-1:0] src_val;
    logic [XLEN-1:0] result;
    logic            res_zero;

    ialu_decode u_dec (
        .word   (instr_word),
        .fields (fld),
        .sel    (sel),
        .legal  (legal)
    );

    ialu_cond u_cond (
        .cond (fld.cond),
        .z    (st_q.z),
        .pass (pass)
    );

    assign src_val = st_q.rf[fld.src];

    ialu_alu #(.W(XLEN), .IW(IMM_W)) u_alu (
        .sel  (sel),
        .a    (src_val),
        .imm  (fld.imm),
        .y    (result),
        .zero (res_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.retire  = 1'b0;
        st_d.skipped = 1'b0;
        st_d.illegal = 1'b0;
        if (instr_valid) begin
            if (!pass) begin
                st_d.skipped = 1'b1;
            end else if (!legal) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.rf[fld.dst] = result;
                st_d.retire      = 1'b1;
                if (fld.upd_z) begin
                    st_d.z = res_zero;
                end
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data = st_q.rf[rd_sel];
    assign z_flag  = st_q.z;
    assign retire  = st_q.retire;
    assign skipped = st_q.skipped;
    assign illegal = st_q.illegal;
endmodule

// File: rtl/ialu_exec_chk.sv
module ialu_exec_chk
    import ialu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic [XLEN-1:0] instr_word,
    input logic [RA_W-1:0] rd_sel,
    input logic [XLEN-1:0] rd_data,
    input logic            z_flag,
    input logic            retire,
    input logic            skipped,
    input logic            illegal
);
    // R5
    outcome_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retire, skipped, illegal}));

    // R10
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !retire && !skipped && !illegal);

    // R2
    always_exec_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid && instr_word[31:28] == CC_ALWAYS |=> retire || illegal);

    // R5
    skip_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
        skipped |-> $stable(z_flag));

    // R5
    skip_keeps_reg_chk: assert property (@(posedge clk) disable iff (rst)
        skipped && $stable(rd_sel) |-> $stable(rd_data));

    // R6
    illegal_keeps_reg_chk: assert property (@(posedge clk) disable iff (rst)
        illegal && $stable(rd_sel) |-> $stable(rd_data) && $stable(z_flag));

    // R7
    no_update_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid && !instr_word[20] |=> $stable(z_flag));

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == '0 && !z_flag && !retire && !skipped && !illegal);
endmodule

bind ialu_exec ialu_exec_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .z_flag      (z_flag),
    .retire      (retire),
    .skipped     (skipped),
    .illegal     (illegal)
);

// File: tb/ialu_exec_tb_top.sv
`timescale 1ns/100ps
module ialu_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        z_flag, retire, skipped, illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_rf [16];
    logic        m_z;

    always #2.5 clk = ~clk;

    ialu_exec dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .rd_sel(rd_sel), .rd_data(rd_data), .z_flag(z_flag),
        .retire(retire), .skipped(skipped), .illegal(illegal)
    );

    function automatic logic [31:0] enc(logic [3:0] cc, logic [6:0] op, logic s,
                                        logic [3:0] rn, logic [3:0] rd, logic [11:0] imm);
        return {cc, op, s, rn, rd, imm};
    endfunction

    function automatic bit cond_ok(logic [3:0] cc, logic z);
        if (cc == 4'b0000) return z;
        if (cc == 4'b0001) return !z;
        return cc == 4'b1110;
    endfunction

    function automatic bit op_known(logic [6:0] op);
        return op == 7'h04 || op == 7'h02 || op == 7'h00 || op == 7'h0C || op == 7'h01;
    endfunction

    function automatic logic [31:0] op_eval(logic [6:0] op, logic [31:0] a, logic [11:0] imm);
        logic [31:0] b = {20'd0, imm};
        case (op)
            7'h04:   return a + b;
            7'h02:   return a - b;
            7'h00:   return a & b;
            7'h0C:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_rf[i] = '0;
        m_z = 1'b0;
    endtask

    task automatic issue(logic [31:0] w, string req);
        bit p, k;
        logic [31:0] res;
        p   = cond_ok(w[31:28], m_z);
        k   = op_known(w[27:21]);
        res = op_eval(w[27:21], m_rf[w[19:16]], w[11:0]);
        instr_word  = w;
        instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        chk({req, " R4 retire"}, {31'd0, retire}, {31'd0, p && k});
        chk({req, " R5 skipped"}, {31'd0, skipped}, {31'd0, !p});
        chk({req, " R6 illegal"}, {31'd0, illegal}, {31'd0, p && !k});
        if (p && k) begin
            m_rf[w[15:12]] = res;
            if (w[20]) m_z = (res == '0);
        end
        rd_sel = w[15:12];
        #1;
        chk({req, " R3 dst"}, rd_data, m_rf[w[15:12]]);
        chk({req, " R7 z"}, {31'd0, z_flag}, {31'd0, m_z});
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 16; i++) begin
            rd_sel = i[3:0];
            #0.5;
            chk(req, rd_data, m_rf[i]);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        sweep("R8 reset regs");
        chk("R8 reset flags", {28'd0, z_flag, retire, skipped, illegal}, 32'd0);

        // R1 R3 directed
        issue(enc(4'b1110, 7'h0C, 1'b0, 4'd0, 4'd1, 12'hABC), "R1 orr");
        issue(enc(4'b1110, 7'h04, 1'b0, 4'd1, 4'd2, 12'hFFF), "R3 add");
        issue(enc(4'b1110, 7'h00, 1'b0, 4'd2, 4'd3, 12'h0F0), "R3 and");
        issue(enc(4'b1110, 7'h01, 1'b0, 4'd2, 4'd4, 12'h555), "R3 eor");
        // R9 src == dst
        issue(enc(4'b1110, 7'h04, 1'b0, 4'd1, 4'd1, 12'h001), "R9 same reg");
        // R2 EQ with Z=0 skipped, NE executes
        issue(enc(4'b0000, 7'h04, 1'b0, 4'd1, 4'd5, 12'h111), "R2 eq fail");
        issue(enc(4'b0001, 7'h04, 1'b0, 4'd1, 4'd5, 12'h111), "R2 ne pass");
        // R7 zero result, update bit clear: Z stays 0
        issue(enc(4'b1110, 7'h02, 1'b0, 4'd0, 4'd6, 12'h000), "R7 no upd");
        // R3 wrap: 0 - 1, then +1 sets Z
        issue(enc(4'b1110, 7'h02, 1'b1, 4'd0, 4'd7, 12'h001), "R3 sub wrap");
        issue(enc(4'b1110, 7'h04, 1'b1, 4'd7, 4'd8, 12'h001), "R7 add wrap z");
        issue(enc(4'b0000, 7'h0C, 1'b0, 4'd0, 4'd9, 12'h123), "R2 eq pass");
        issue(enc(4'b0001, 7'h0C, 1'b0, 4'd0, 4'd9, 12'h456), "R2 ne fail");
        // R5 reserved condition with unknown opcode
        issue(enc(4'b0101, 7'h7F, 1'b1, 4'd1, 4'd1, 12'hFFF), "R5 reserved cc");
        issue(enc(4'b1111, 7'h04, 1'b1, 4'd1, 4'd1, 12'hFFF), "R5 cc 1111");
        // R6 unknown opcode
        issue(enc(4'b1110, 7'h7F, 1'b1, 4'd1, 4'd1, 12'h000), "R6 bad opc");
        // R10 idle cycles
        repeat (3) begin
            @(negedge clk);
            chk("R10 idle pulses", {29'd0, retire, skipped, illegal}, 32'd0);
        end
        sweep("R10 idle regs");

        // random
        for (int n = 0; n < 600; n++) begin
            logic [3:0] cc;
            logic [6:0] op;
            int r = $urandom % 8;
            cc = (r < 2) ? 4'b0000 : (r < 4) ? 4'b0001 : (r < 7) ? 4'b1110 : 4'($urandom);
            case ($urandom % 12)
                0, 1:    op = 7'h04;
                2, 3:    op = 7'h02;
                4, 5:    op = 7'h00;
                6, 7:    op = 7'h0C;
                8, 9:    op = 7'h01;
                default: op = 7'($urandom);
            endcase
            issue(enc(cc, op, 1'($urandom), 4'($urandom), 4'($urandom), 12'($urandom)), "R3 random");
        end
        sweep("R3 random regs");

        // R8 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        sweep("R8 mid reset regs");
        chk("R8 mid reset z", {31'd0, z_flag}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule